// File: doc/BRIEF.md
# PS/2 Host Frame Receiver

This block is the host end of a PS/2-style link for traffic that flows from the device to the host. The device drives both open-collector lines and generates the slow serial clock. The receiver first passes its copies of Clock and Data through a two-flop synchronizer. It then debounces each line and shifts in one bit on every filtered falling Clock edge. After the eleventh bit it either presents the byte with a one-cycle valid strobe or reports why the frame was rejected.

The host can stop the device from talking by asserting `inhibit_i`. The block then enables an open-drain pull-down on Clock (`ps2_clk_oe_o`) and keeps it on for a guaranteed minimum time. Any frame that was partly received is thrown away. If the device stops clocking in the middle of a frame, a stall timer ends that frame. All microsecond timings are turned into cycle counts from the system-clock frequency parameter.

Top module: `ps2_rx_host`

## Requirements
- R1: A frame of eleven bits (start bit 0, eight data bits least significant first, parity bit, stop bit 1) whose data plus parity hold an odd number of ones produces a single-cycle `rx_valid_o` pulse, with the byte on `rx_data_o` and `rx_err_o` low.
- R2: A frame with correct start and stop bits but an even count of ones over data and parity gives a single-cycle `rx_err_o` pulse with `rx_err_kind_o` = 2'd1 and no valid pulse.
- R3: A start bit sampled as 1 or a stop bit sampled as 0 gives `rx_err_o` with `rx_err_kind_o` = 2'd2 and no valid pulse. A framing fault takes precedence over a parity fault.
- R4: Bits are sampled on falling edges of the filtered Clock. A level change on either line that lasts fewer than FILT_CYC system cycles is ignored.
- R5: If no filtered falling edge arrives for TIMEOUT_US microseconds (converted to cycles with CLK_HZ) after a frame has started, the receiver returns to idle and pulses `rx_err_o` with `rx_err_kind_o` = 2'd3. It reports nothing while the gap is shorter than that.
- R6: `ps2_clk_oe_o` rises on the clock edge that first sees `inhibit_i` high. It stays high while `inhibit_i` is high, and in total for at least INHIBIT_US microseconds converted to cycles. For a short request it stays high exactly that long.
- R7: While the host inhibits, a partly received frame is discarded with no valid or error pulse, and the next complete frame is received correctly.
- R8: During and right after reset, `rx_valid_o`, `rx_err_o`, `rx_err_kind_o`, `rx_data_o` and `ps2_clk_oe_o` are all zero.
- R9: `rx_valid_o` and `rx_err_o` are never high together. `rx_err_kind_o` is 2'd0 whenever `rx_err_o` is low. `rx_data_o` keeps the last good byte through rejected frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Clock line as seen at the pad (asynchronous) |
| ps2_data_i | input | 1 | Data line as seen at the pad (asynchronous) |
| inhibit_i | input | 1 | Host request to hold Clock low |
| ps2_clk_oe_o | output | 1 | Enables the open-drain pull-down on Clock |
| rx_data_o | output | 8 | Last byte received without error |
| rx_valid_o | output | 1 | One-cycle strobe for a good byte |
| rx_err_o | output | 1 | One-cycle strobe for a rejected frame |
| rx_err_kind_o | output | 2 | 1 parity, 2 framing, 3 stall timeout, 0 otherwise |

## Verification
The bench sets CLK_HZ to 1 MHz, so one system cycle stands for one microsecond. The stall limit is then 200 cycles, the minimum inhibit is 100 cycles, and the filter length is 4 cycles. At these values a full eleven-bit frame lasts under a thousand cycles. Dozens of random frames with injected parity and framing faults fit in the run, together with an exact count of the inhibit hold time and checks of the stall timer on both sides of its limit.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE    = 2'd0,
    FAULT_PARITY  = 2'd1,
    FAULT_FRAMING = 2'd2,
    FAULT_STALL   = 2'd3
  } fault_e;

  localparam int FRAME_BITS = 11;

  // Classify a complete frame; bit 0 is the first bit on the wire.
  function automatic fault_e judge_frame(input logic [FRAME_BITS-1:0] f);
    if (f[0] != 1'b0 || f[10] != 1'b1) return FAULT_FRAMING;
    if ((^f[9:1]) != 1'b1)             return FAULT_PARITY;
    return FAULT_NONE;
  endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o,
  output logic fell_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   s;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign s = sync_q[SYNC_STAGES-1];

  // A new level is accepted only after FILT_CYC consecutive differing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 1'b1;
      run_q   <= '0;
      fell_o  <= 1'b0;
    end else begin
      fell_o <= 1'b0;
      if (s == level_o) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_CYC - 1)) begin
        level_o <= s;
        run_q   <= '0;
        fell_o  <= level_o;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2_inhibit_ctl.sv
module ps2_inhibit_ctl #(
  parameter int HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic inhibit_i,
  output logic drive_low_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_low_o <= 1'b0;
      held_q      <= '0;
    end else if (!drive_low_o) begin
      if (inhibit_i) begin
        drive_low_o <= 1'b1;
        held_q      <= '0;
      end
    end else if (!inhibit_i && held_q >= CW'(HOLD_CYC - 1)) begin
      drive_low_o <= 1'b0;
    end else if (held_q < CW'(HOLD_CYC - 1)) begin
      held_q <= held_q + 1'b1;
    end
  end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int STALL_CYC = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fell_i,
  input  logic       data_i,
  input  logic       abort_i,
  output logic [7:0] byte_o,
  output logic       valid_o,
  output logic       err_o,
  output logic [1:0] kind_o
);
  localparam int TW = $clog2(STALL_CYC + 1);

  logic [3:0]              nbits_q;
  logic [FRAME_BITS-2:0]   shreg_q;
  logic [TW-1:0]           idle_q;
  logic [FRAME_BITS-1:0]   whole;
  fault_e                  verdict;

  assign whole   = {data_i, shreg_q};
  assign verdict = judge_frame(whole);

  always_ff @(posedge clk) begin
    if (rst) begin
      nbits_q <= '0;
      shreg_q <= '0;
      idle_q  <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      kind_o  <= FAULT_NONE;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      kind_o  <= FAULT_NONE;
      if (abort_i) begin
        nbits_q <= '0;
        idle_q  <= '0;
      end else if (fell_i) begin
        idle_q <= '0;
        if (nbits_q == 4'(FRAME_BITS - 1)) begin
          nbits_q <= '0;
          if (verdict == FAULT_NONE) begin
            valid_o <= 1'b1;
            byte_o  <= whole[8:1];
          end else begin
            err_o  <= 1'b1;
            kind_o <= verdict;
          end
        end else begin
          nbits_q <= nbits_q + 1'b1;
          shreg_q <= {data_i, shreg_q[FRAME_BITS-2:1]};
        end
      end else if (nbits_q != '0) begin
        if (idle_q == TW'(STALL_CYC - 1)) begin
          nbits_q <= '0;
          idle_q  <= '0;
          err_o   <= 1'b1;
          kind_o  <= FAULT_STALL;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_rx_host.sv
module ps2_rx_host #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int FILT_CYC    = 8,
  parameter int TIMEOUT_US  = 200,
  parameter int INHIBIT_US  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  input  logic       inhibit_i,
  output logic       ps2_clk_oe_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       rx_err_o,
  output logic [1:0] rx_err_kind_o
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int STALL_CYC  = TIMEOUT_US * CYC_PER_US;
  localparam int HOLD_CYC   = INHIBIT_US * CYC_PER_US;
  localparam int N_LINES    = 2;

  logic [N_LINES-1:0] raw, lvl, fell;

  assign raw = {ps2_data_i, ps2_clk_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    ps2_line_filter #(.SYNC_STAGES(2), .FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw[g]),
      .level_o(lvl[g]),
      .fell_o (fell[g])
    );
  end

  ps2_inhibit_ctl #(.HOLD_CYC(HOLD_CYC)) u_inh (
    .clk        (clk),
    .rst        (rst),
    .inhibit_i  (inhibit_i),
    .drive_low_o(ps2_clk_oe_o)
  );

  ps2_frame_rx #(.STALL_CYC(STALL_CYC)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .fell_i (fell[0]),
    .data_i (lvl[1]),
    .abort_i(ps2_clk_oe_o | inhibit_i),
    .byte_o (rx_data_o),
    .valid_o(rx_valid_o),
    .err_o  (rx_err_o),
    .kind_o (rx_err_kind_o)
  );
endmodule

// File: rtl/ps2_rx_host_chk.sv
module ps2_rx_host_chk #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int INHIBIT_US = 100
) (
  input logic       clk,
  input logic       rst,
  input logic       inhibit_i,
  input logic       ps2_clk_oe_o,
  input logic       rx_valid_o,
  input logic       rx_err_o,
  input logic [1:0] rx_err_kind_o
);
  localparam int HOLD = INHIBIT_US * (CLK_HZ / 1_000_000);
  localparam int CW   = $clog2(HOLD + 2);

  logic [CW-1:0] oe_len_q;

  always_ff @(posedge clk) begin
    if (rst || !ps2_clk_oe_o) oe_len_q <= '0;
    else if (oe_len_q < CW'(HOLD + 1)) oe_len_q <= oe_len_q + 1'b1;
  end

  p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid_o && rx_err_o));

  p_kind_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_err_o |-> rx_err_kind_o == 2'd0);

  p_err_has_kind_r2: assert property (@(posedge clk) disable iff (rst)
    rx_err_o |-> rx_err_kind_o != 2'd0);

  p_valid_single_r1: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  p_quiet_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
    ps2_clk_oe_o |-> !rx_valid_o && !rx_err_o);

  p_min_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ps2_clk_oe_o) |-> oe_len_q >= CW'(HOLD));

  p_hold_while_req_r6: assert property (@(posedge clk) disable iff (rst)
    ps2_clk_oe_o && inhibit_i |=> ps2_clk_oe_o);
endmodule

bind ps2_rx_host ps2_rx_host_chk #(.CLK_HZ(CLK_HZ), .INHIBIT_US(INHIBIT_US)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .inhibit_i    (inhibit_i),
  .ps2_clk_oe_o (ps2_clk_oe_o),
  .rx_valid_o   (rx_valid_o),
  .rx_err_o     (rx_err_o),
  .rx_err_kind_o(rx_err_kind_o)
);

// File: tb/tb_ps2_rx_host.sv
module tb_ps2_rx_host;
  localparam int CLK_HZ = 1_000_000;
  localparam int FILT   = 4;
  localparam int TO_US  = 200;
  localparam int INH_US = 100;
  localparam int HALF   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_clk = 1'b1, dev_data = 1'b1, inhibit_i = 1'b0;
  logic ps2_clk_oe_o, rx_valid_o, rx_err_o;
  logic [7:0] rx_data_o;
  logic [1:0] rx_err_kind_o;
  logic ps2_clk_line;

  int n_cmp = 0, n_bad = 0;
  int n_valid = 0, n_err = 0;
  logic [7:0] last_byte = '0;
  logic [1:0] last_kind = '0;
  logic [7:0] good_byte = '0;

  always #10 clk = ~clk;

  assign ps2_clk_line = dev_clk & ~ps2_clk_oe_o;

  ps2_rx_host #(.CLK_HZ(CLK_HZ), .FILT_CYC(FILT), .TIMEOUT_US(TO_US), .INHIBIT_US(INH_US)) dut (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk_line), .ps2_data_i(dev_data),
    .inhibit_i(inhibit_i), .ps2_clk_oe_o(ps2_clk_oe_o), .rx_data_o(rx_data_o),
    .rx_valid_o(rx_valid_o), .rx_err_o(rx_err_o), .rx_err_kind_o(rx_err_kind_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid_o) begin n_valid++; last_byte = rx_data_o; end
      if (rx_err_o)   begin n_err++;   last_kind = rx_err_kind_o; end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] d, input int fault);
    logic par = ~^d;
    logic st = 1'b0, sp = 1'b1;
    if (fault == 1) par = ~par;
    if (fault == 2) st = 1'b1;
    if (fault == 3) sp = 1'b0;
    return {sp, par, d, st};
  endfunction

  function automatic int exp_kind(input int fault);
    if (fault == 0) return 0;
    if (fault == 1) return 1;
    return 2;
  endfunction

  task automatic send_bits(input logic [10:0] f, input int nb);
    for (int i = 0; i < nb; i++) begin
      dev_data = f[i];
      cyc(HALF / 2);
      dev_clk = 1'b0;
      cyc(HALF);
      dev_clk = 1'b1;
      cyc(HALF / 2);
    end
    dev_data = 1'b1;
  endtask

  task automatic run_frame(input logic [7:0] d, input int fault, input string req);
    int v0 = n_valid, e0 = n_err;
    send_bits(mk_frame(d, fault), 11);
    cyc(30);
    if (fault == 0) begin
      chk(n_valid - v0 == 1 && n_err == e0, req, n_valid - v0, 1);
      chk(last_byte == d, req, last_byte, d);
      good_byte = d;
    end else begin
      chk(n_err - e0 == 1 && n_valid == v0, req, n_err - e0, 1);
      chk(int'(last_kind) == exp_kind(fault), req, last_kind, exp_kind(fault));
      chk(rx_data_o == good_byte, "R9 data kept", rx_data_o, good_byte);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v0, e0, hi;
    void'($urandom(32'h5eed_0042));
    cyc(6);
    // R8: reset state
    chk(rx_valid_o == 0 && rx_err_o == 0 && rx_err_kind_o == 0, "R8 strobes", rx_valid_o, 0);
    chk(rx_data_o == 0 && ps2_clk_oe_o == 0, "R8 data/oe", rx_data_o, 0);
    rst = 1'b0;
    cyc(20);
    chk(rx_valid_o == 0 && rx_err_o == 0 && ps2_clk_oe_o == 0, "R8 after", rx_err_o, 0);

    // R1 directed
    run_frame(8'h15, 0, "R1 0x15");
    run_frame(8'h00, 0, "R1 0x00");
    run_frame(8'hFF, 0, "R1 0xFF");
    // R2 / R3 directed
    run_frame(8'hA5, 1, "R2 parity");
    run_frame(8'h3C, 2, "R3 start");
    run_frame(8'hC3, 3, "R3 stop");
    // R3 precedence over parity: bad stop and bad parity together
    v0 = n_valid; e0 = n_err;
    send_bits(mk_frame(8'h5A, 3) ^ 11'b010_0000_0000, 11);
    cyc(30);
    chk(n_err - e0 == 1 && last_kind == 2'd2, "R3 precedence", last_kind, 2);

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d = 8'($urandom);
      int fault = ($urandom % 3 == 0) ? int'($urandom % 4) : 0;
      run_frame(d, fault, fault == 0 ? "R1 random" : (fault == 1 ? "R2 random" : "R3 random"));
    end

    // R4: short glitch on clock while idle is ignored
    dev_clk = 1'b0; cyc(FILT - 2); dev_clk = 1'b1; cyc(20);
    dev_data = 1'b0; cyc(FILT - 2); dev_data = 1'b1; cyc(20);
    run_frame(8'h69, 0, "R4 glitch");

    // R5: stall timeout, checked on both sides of the limit
    v0 = n_valid; e0 = n_err;
    send_bits(mk_frame(8'h77, 0), 5);
    cyc(100);
    chk(n_err == e0, "R5 early", n_err - e0, 0);
    cyc(100);
    chk(n_err - e0 == 1 && last_kind == 2'd3 && n_valid == v0, "R5 stall", last_kind, 3);
    run_frame(8'h81, 0, "R5 recovery");

    // R6 / R7: inhibit during a partial frame
    v0 = n_valid; e0 = n_err;
    send_bits(mk_frame(8'h42, 0), 4);
    inhibit_i = 1'b1;
    hi = 0;
    repeat (10) begin @(negedge clk); if (ps2_clk_oe_o) hi++; end
    inhibit_i = 1'b0;
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (ps2_clk_oe_o) hi++; else break;
    end
    chk(hi == INH_US, "R6 hold", hi, INH_US);
    cyc(30);
    chk(n_valid == v0 && n_err == e0, "R7 discard", n_err - e0, 0);
    run_frame(8'hB4, 0, "R7 next frame");

    // R6: long request holds the line for the whole request
    inhibit_i = 1'b1;
    hi = 0;
    repeat (150) begin @(negedge clk); if (ps2_clk_oe_o) hi++; end
    inhibit_i = 1'b0;
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (ps2_clk_oe_o) hi++; else break;
    end
    chk(hi >= 150 && hi <= 151, "R6 long", hi, 150);
    cyc(30);
    run_frame(8'h1E, 0, "R1 after inhibit");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule